// File: doc/BRIEF.md
# Two-Level Decoded Arithmetic/Logic Unit

This block pairs a 32-bit combinational arithmetic/logic unit with the small decoder that sits in front of it. A two-bit operation class from the main instruction control and the six-bit function field of register-to-register instructions feed the decoder. The decoder turns them into a four-bit operation code. For memory address arithmetic the class forces an addition. For branch comparison it forces a subtraction. For register-to-register work the function field picks the operation.

The operation code is laid out so that the datapath needs almost no further decoding. Its top bit drives the subtract input of the adder, which inverts operand B and sets the carry-in. Its low three bits drive the multiplexer that picks the result. Seven operations are provided: bitwise and, or, xor and nor, plus add, subtract and signed set-less-than. The block also produces a zero flag and a signed overflow flag. It has no clock and no state. All outputs follow the inputs combinationally.

Top module: `alu2_top`

## Requirements
- R1: When `alu_op` is 00, `alu_ctrl` is 0110 (add) whatever the value of `funct`, and the result is A + B.
- R2: When `alu_op` is 01, `alu_ctrl` is 1110 (subtract) whatever the value of `funct`, and the result is A - B.
- R3: When `alu_op[1]` is 1, `funct` is decoded as follows: 100000 gives 0110 (add), 100010 gives 1110 (subtract), 100100 gives 0000 (and), 100101 gives 0001 (or), 100110 gives 0010 (xor), 100111 gives 0011 (nor), and 101010 gives 1111 (set-less-than).
- R4: When `alu_op[1]` is 1 and `funct` is any other value, `alu_ctrl` is 0000 and the unit performs a bitwise and.
- R5: Codes 0000, 0001, 0010 and 0011 give the bitwise and, or, xor and nor of A and B.
- R6: Codes 0110 and 1110 give A + B and A - B modulo 2^32. Bit 3 of the code alone selects subtraction.
- R7: Code 1111 gives 1 in bit 0 when signed A is less than signed B, and 0 otherwise, with all other result bits 0. The answer stays correct when A - B overflows.
- R8: `ovf` is 1 only for codes 0110 and 1110, and only when the signed result does not fit in 32 bits. For every other code it is 0.
- R9: `zero` is 1 exactly when all 32 bits of `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op | input | 2 | Operation class from the main control: 00 add, 01 subtract, 1x decode `funct` |
| funct | input | 6 | Function field of a register-to-register instruction |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| alu_ctrl | output | 4 | Decoded operation code |
| result | output | 32 | Selected result |
| zero | output | 1 | High when `result` is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The hardest case to reach from the ports is set-less-than while the internal subtraction overflows. Here the sign bit of the difference gives the wrong answer, and only its correction by the overflow term makes the comparison right. Uniformly drawn operands almost never pair the most negative value with a positive one, or the most positive value with a negative one. The stimulus therefore places such extreme pairs directly, under both the forced-subtract class and the decoded compare. It does the same for the add and subtract overflow boundaries. It then mixes in drawn operands whose classes and function codes include unlisted values.

// File: rtl/alu2_pkg.sv
package alu2_pkg;

  // operation code seen by the datapath: bit 3 = subtract, bit 2 = arithmetic group,
  // bits 1:0 = result select inside the group
  typedef enum logic [3:0] {
    CTL_AND = 4'b0000,
    CTL_OR  = 4'b0001,
    CTL_XOR = 4'b0010,
    CTL_NOR = 4'b0011,
    CTL_ADD = 4'b0110,
    CTL_SUB = 4'b1110,
    CTL_SLT = 4'b1111
  } alu_ctl_e;

  localparam logic [1:0] AOP_ADD = 2'b00;
  localparam logic [1:0] AOP_SUB = 2'b01;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_XOR = 6'b100110;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;

  function automatic alu_ctl_e fn_decode(logic [5:0] fn);
    case (fn)
      FN_ADD:  return CTL_ADD;
      FN_SUB:  return CTL_SUB;
      FN_AND:  return CTL_AND;
      FN_OR:   return CTL_OR;
      FN_XOR:  return CTL_XOR;
      FN_NOR:  return CTL_NOR;
      FN_SLT:  return CTL_SLT;
      default: return CTL_AND;
    endcase
  endfunction

  function automatic logic bit_logic(logic [1:0] sel, logic x, logic y);
    case (sel)
      2'b00:   return x & y;
      2'b01:   return x | y;
      2'b10:   return x ^ y;
      default: return ~(x | y);
    endcase
  endfunction

endpackage

// File: rtl/alu2_ctrl_dec.sv
module alu2_ctrl_dec
  import alu2_pkg::*;
(
  input  logic [1:0] alu_op,
  input  logic [5:0] funct,
  output alu_ctl_e   ctrl
);

  always_comb begin
    if (alu_op[1])
      ctrl = fn_decode(funct);
    else if (alu_op == AOP_SUB)
      ctrl = CTL_SUB;
    else
      ctrl = CTL_ADD;
  end

endmodule

// File: rtl/alu2_addsub.sv
module alu2_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             ovf_raw,
  output logic             less
);

  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] add_cin(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y,
                                               logic cin);
    return x + y + {{(WIDTH-1){1'b0}}, cin};
  endfunction

  function automatic logic sign_ovf(logic xs, logic ys, logic ss);
    return (xs == ys) && (ss != xs);
  endfunction

  logic [WIDTH-1:0] b_eff;

  assign b_eff   = sub ? ~b : b;
  assign sum     = add_cin(a, b_eff, sub);
  assign ovf_raw = sign_ovf(a[MSB], b_eff[MSB], sum[MSB]);
  assign less    = sum[MSB] ^ ovf_raw;

endmodule

// File: rtl/alu2_logic.sv
module alu2_logic
  import alu2_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       sel,
  output logic [WIDTH-1:0] y
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign y[i] = bit_logic(sel, a[i], b[i]);
  end

endmodule

// File: rtl/alu2_top.sv
module alu2_top
  import alu2_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       alu_op,
  input  logic [5:0]       funct,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [3:0]       alu_ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             ovf
);

  alu_ctl_e         ctl;
  logic             sub_sel;
  logic             arith_grp;
  logic [1:0]       mux_sel;
  logic [WIDTH-1:0] sum;
  logic             ovf_raw;
  logic             less;
  logic [WIDTH-1:0] logic_y;

  alu2_ctrl_dec u_dec (
    .alu_op (alu_op),
    .funct  (funct),
    .ctrl   (ctl)
  );

  assign alu_ctrl  = ctl;
  assign sub_sel   = ctl[3];
  assign arith_grp = ctl[2];
  assign mux_sel   = ctl[1:0];

  alu2_addsub #(.WIDTH(WIDTH)) u_add (
    .a       (opnd_a),
    .b       (opnd_b),
    .sub     (sub_sel),
    .sum     (sum),
    .ovf_raw (ovf_raw),
    .less    (less)
  );

  alu2_logic #(.WIDTH(WIDTH)) u_log (
    .a   (opnd_a),
    .b   (opnd_b),
    .sel (mux_sel),
    .y   (logic_y)
  );

  always_comb begin
    if (!arith_grp)
      result = logic_y;
    else if (mux_sel[0])
      result = {{(WIDTH-1){1'b0}}, less};
    else
      result = sum;
  end

  assign ovf  = arith_grp & ~mux_sel[0] & ovf_raw;
  assign zero = ~|result;

endmodule

// File: rtl/alu2_chk.sv
module alu2_chk #(
  parameter int WIDTH = 32
) (
  input logic [1:0]       alu_op,
  input logic [5:0]       funct,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [3:0]       alu_ctrl,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             ovf
);

  always_comb begin
    AST_OP00_ADD: assert (!(alu_op == 2'b00) || alu_ctrl == 4'b0110)
      else $error("add class not forced"); // R1
    AST_OP01_SUB: assert (!(alu_op == 2'b01) || alu_ctrl == 4'b1110)
      else $error("subtract class not forced"); // R2
    AST_CTRL_LEGAL: assert (alu_ctrl inside {4'b0000, 4'b0001, 4'b0010, 4'b0011,
                                             4'b0110, 4'b1110, 4'b1111})
      else $error("illegal operation code"); // R3
    AST_UNKNOWN_FN_AND: assert (!(alu_op[1] && !funct[5]) || alu_ctrl == 4'b0000)
      else $error("unlisted function not mapped to and"); // R4
    AST_AND_SUBSET: assert (!(alu_ctrl == 4'b0000) || (result & ~opnd_a) == '0)
      else $error("and result has bits outside A"); // R5
    AST_SLT_UPPER: assert (!(alu_ctrl == 4'b1111) || result[WIDTH-1:1] == '0)
      else $error("compare result has upper bits"); // R7
    AST_OVF_ONLY_ARITH: assert (!ovf || alu_ctrl == 4'b0110 || alu_ctrl == 4'b1110)
      else $error("overflow outside add or subtract"); // R8
    AST_SUB_EQUAL_ZERO: assert (!(alu_ctrl == 4'b1110 && opnd_a == opnd_b) || (zero && !ovf))
      else $error("equal subtract not zero"); // R9
  end

endmodule

bind alu2_top alu2_chk #(.WIDTH(WIDTH)) u_chk (
  .alu_op   (alu_op),
  .funct    (funct),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .alu_ctrl (alu_ctrl),
  .result   (result),
  .zero     (zero),
  .ovf      (ovf)
);

// File: tb/alu2_top_tb_top.sv
module alu2_top_tb_top;

  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    alu_op = 2'b00;
  logic [5:0]    funct = 6'd0;
  logic [W-1:0]  opnd_a = '0;
  logic [W-1:0]  opnd_b = '0;
  logic [3:0]    alu_ctrl;
  logic [W-1:0]  result;
  logic          zero;
  logic          ovf;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alu2_top #(.WIDTH(W)) dut_i (
    .alu_op   (alu_op),
    .funct    (funct),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .alu_ctrl (alu_ctrl),
    .result   (result),
    .zero     (zero),
    .ovf      (ovf)
  );

  // behavioural reference
  function automatic logic [3:0] ref_ctrl(logic [1:0] op, logic [5:0] fn);
    if (op == 2'b00) return 4'd6;
    if (op == 2'b01) return 4'd14;
    case (fn)
      6'd32:   return 4'd6;
      6'd34:   return 4'd14;
      6'd36:   return 4'd0;
      6'd37:   return 4'd1;
      6'd38:   return 4'd2;
      6'd39:   return 4'd3;
      6'd42:   return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

  function automatic string ctrl_req(logic [1:0] op, logic [5:0] fn);
    if (op == 2'b00) return "R1";
    if (op == 2'b01) return "R2";
    if (fn inside {6'd32, 6'd34, 6'd36, 6'd37, 6'd38, 6'd39, 6'd42}) return "R3";
    return "R4";
  endfunction

  task automatic check_vec(string what);
    logic [3:0]  ec;
    logic [W-1:0] er;
    logic        eo;
    longint      sa, sb, s;
    string       rq;
    ec = ref_ctrl(alu_op, funct);
    sa = longint'($signed(opnd_a));
    sb = longint'($signed(opnd_b));
    eo = 1'b0;
    s  = 0;
    rq = "R5";
    case (ec)
      4'd0:  er = opnd_a & opnd_b;
      4'd1:  er = opnd_a | opnd_b;
      4'd2:  er = opnd_a ^ opnd_b;
      4'd3:  er = ~(opnd_a | opnd_b);
      4'd6:  begin s = sa + sb; rq = "R6"; end
      4'd14: begin s = sa - sb; rq = "R6"; end
      default: begin er = (sa < sb) ? 1 : 0; rq = "R7"; end
    endcase
    if (ec == 4'd6 || ec == 4'd14) begin
      er = s[W-1:0];
      eo = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    end
    n_cmp++;
    if (alu_ctrl !== ec) begin
      n_bad++;
      $display("FAIL %s ctrl (%s): actual=%b expected=%b", ctrl_req(alu_op, funct), what, alu_ctrl, ec);
    end
    n_cmp++;
    if (result !== er) begin
      n_bad++;
      $display("FAIL %s result (%s): actual=%h expected=%h", rq, what, result, er);
    end
    n_cmp++;
    if (ovf !== eo) begin
      n_bad++;
      $display("FAIL R8 ovf (%s): actual=%b expected=%b", what, ovf, eo);
    end
    n_cmp++;
    if (zero !== (er == '0)) begin
      n_bad++;
      $display("FAIL R9 zero (%s): actual=%b expected=%b", what, zero, (er == '0));
    end
  endtask

  task automatic apply(logic [1:0] op, logic [5:0] fn, logic [W-1:0] a, logic [W-1:0] b,
                       string what);
    @(posedge clk);
    #1;
    alu_op = op;
    funct  = fn;
    opnd_a = a;
    opnd_b = b;
    @(negedge clk);
    check_vec(what);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_vec("reset state R9");
    rst_n = 1'b1;

    apply(2'b00, 6'd34, 32'd5, 32'd7, "R1 class add ignores subtract funct");
    apply(2'b00, 6'd36, 32'h7fffffff, 32'd1, "R1 R8 add overflow");
    apply(2'b01, 6'd37, 32'd9, 32'd9, "R2 R9 equal subtract");
    apply(2'b01, 6'd32, 32'h80000000, 32'd1, "R2 R8 subtract overflow");
    apply(2'b10, 6'd32, 32'hffffffff, 32'd1, "R3 R9 add wraps to zero");
    apply(2'b10, 6'd36, 32'hf0f0_1234, 32'h0ff0_ffff, "R3 R5 and");
    apply(2'b10, 6'd37, 32'hf000_0000, 32'h0000_000f, "R3 R5 or");
    apply(2'b10, 6'd38, 32'hdead_beef, 32'hdead_beef, "R5 R9 xor equal");
    apply(2'b10, 6'd39, 32'd0, 32'd0, "R5 nor of zeros");
    apply(2'b10, 6'd42, 32'h80000000, 32'd1, "R7 compare with overflowing difference");
    apply(2'b10, 6'd42, 32'd1, 32'h80000000, "R7 compare reversed");
    apply(2'b10, 6'd42, 32'h7fffffff, 32'hffffffff, "R7 R8 compare no ovf flag");
    apply(2'b10, 6'd42, 32'd4, 32'd4, "R7 R9 compare equal");
    apply(2'b10, 6'd34, 32'h7fffffff, 32'hffffffff, "R6 R8 subtract positive overflow");
    apply(2'b10, 6'd0, 32'hffff_0000, 32'h00ff_ff00, "R4 unlisted funct 000000");
    apply(2'b11, 6'd63, 32'h1234_5678, 32'hffff_ffff, "R4 unlisted funct 111111");
    apply(2'b11, 6'd34, 32'd3, 32'd10, "R3 R6 class 11 decodes funct");

    for (int k = 0; k < 400; k++) begin
      logic [5:0] fn;
      logic [W-1:0] a, b;
      case ($urandom_range(0, 8))
        0: fn = 6'd32; 1: fn = 6'd34; 2: fn = 6'd36; 3: fn = 6'd37;
        4: fn = 6'd38; 5: fn = 6'd39; 6: fn = 6'd42;
        default: fn = 6'($urandom);
      endcase
      a = $urandom;
      b = $urandom;
      if (k % 7 == 0) a = {a[W-1], {(W-1){~a[W-1]}}};
      if (k % 5 == 0) b = a;
      apply(2'($urandom), fn, a, b, "R3 R6 R7 drawn vector");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule